// File: doc/BRIEF.md
# Chained Descriptor DMA Channel with Row/Stride Mode

This block is one DMA channel that walks a linked list of transfer descriptors held in memory. Software places descriptors in memory, then pulses `start` with the address of the first one. The channel reads the six words of each descriptor, moves 32-bit words from a source address to a destination address, then follows the descriptor's link word to the next one. A descriptor can describe either one flat run of bytes, or a two-dimensional block: a number of equal rows, with a signed jump applied to the source and destination addresses between rows. Either side of a transfer can be switched off per descriptor, so that a descriptor can fill memory with zeros or read without writing.

While it runs, the channel shows the current descriptor address, the live source and destination addresses and the remaining length. When a descriptor finishes, a done flag is raised, and an interrupt is raised as well if the descriptor asks for one. Both flags stay set until they are cleared through their own inputs. Memory is reached through a single-beat request port. A request is held with a stable address until `mem_ack` is sampled high, and read data is taken in the cycle of the acknowledge.

The controller has these states. ST_IDLE waits for `start`. ST_FETCH reads descriptor word 0 to 5 and keeps a word index. ST_SETUP decides between a data phase and an empty descriptor. ST_READ fetches one source word, or supplies zero. ST_WRITE stores that word, or skips the store. ST_ROWADV applies the row strides. ST_DONE sets the flags and follows the link.

The transitions are:
- IDLE→FETCH on an accepted start.
- FETCH→SETUP on the acknowledge of word 5.
- SETUP→DONE when the row length is zero, otherwise SETUP→READ.
- READ→WRITE once the word is obtained.
- WRITE→READ while bytes remain in the row.
- WRITE→ROWADV at the end of a row that is not the last.
- WRITE→DONE at the end of the last row.
- ROWADV→READ.
- DONE→FETCH when the link is nonzero and the channel is enabled, otherwise DONE→IDLE.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, `active`, `paused`, `end_flag`, `irq` and `mem_req` are 0, and `cur_desc`, `live_src`, `live_dst` and `live_len` are 0.
- R2: A `start` pulse with `chan_en` high and a nonzero `start_addr` sets `active`, clears `paused`, and issues six reads in the order start_addr, +4, +8, +12, +16, +20. These words are, in order: control word, source address, destination address, length, stride, link.
- R3: In flat mode (control bit 1 clear) the length word is the byte count, with its two low bits ignored. Each beat reads the source and then writes that word to the destination. The source address advances by 4 per beat when control bit 8 is set, and the destination address does so when control bit 4 is set. `live_len` shows the bytes left and ends at 0.
- R4: In block mode (control bit 1 set), there are 1 + length[29:16] rows, and each row holds length[15:0] bytes. Between rows, but not after the last row, the signed 16-bit stride[15:0] is added to the source address and the signed stride[31:16] is added to the destination address. `live_len` shows (rows left << 16) | bytes left, and ends at 0x00010000.
- R5: Control bit 11 drops the source read and writes zero instead. Control bit 7 drops the destination write, while the destination address still advances under bit 4.
- R6: When a descriptor ends, `end_flag` is set. If control bit 0 is set, `irq` is also set. A pulse on `clr_end` clears `end_flag` and a pulse on `clr_int` clears `irq`; a set in the same cycle wins.
- R7: When a descriptor ends, `cur_desc` takes the link word. The channel fetches again if the link is nonzero and `chan_en` is high. Otherwise it stops, with `active` at 0 and `paused` at 1; `active` and `paused` are never both high.
- R8: A descriptor whose row byte count is zero ends with no memory access beyond its six fetch reads.
- R9: `start` is ignored while `active` is high and whenever `chan_en` is low. A `start` with address 0 leaves `active` at 0, sets `paused` and loads `cur_desc` with 0.
- R10: While `mem_req` is high and `mem_ack` low, the request, its address and its direction hold unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; checked on start and between descriptors |
| start | input | 1 | Pulse that begins a chain at `start_addr` |
| start_addr | input | AW | Address of the first descriptor |
| clr_end | input | 1 | Clears the done flag |
| clr_int | input | 1 | Clears the interrupt |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| active | output | 1 | Chain in progress |
| paused | output | 1 | Chain stopped after it ran |
| end_flag | output | 1 | A descriptor has completed |
| irq | output | 1 | Interrupt request |
| cur_desc | output | AW | Current descriptor address |
| live_src | output | AW | Live source address |
| live_dst | output | AW | Live destination address |
| live_len | output | 32 | Live remaining length |

## Verification
The assertions assume a memory that eventually acknowledges every request. They also assume that the byte count of a row, once its low two bits are dropped, never needs more beats than the counter holds. The bench's memory model acknowledges within one or two cycles, and it switches between always-ready and alternate-cycle stalls, so the hold rule is tested under back-pressure. Every descriptor the bench builds uses addresses inside the modelled 1 KiB space, and lengths that stay inside that space after strides.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 6;
    localparam int IDX_W      = 3;
    localparam int BYTES_W    = 16;
    localparam int ROWS_W     = 14;
    localparam int STRIDE_W   = 16;

    // control word bit positions
    localparam int CB_IRQ_EN = 0;
    localparam int CB_BLOCK  = 1;
    localparam int CB_DINC   = 4;
    localparam int CB_DSKIP  = 7;
    localparam int CB_SINC   = 8;
    localparam int CB_SSKIP  = 11;

    // descriptor word slots
    localparam int SLOT_CTL  = 0;
    localparam int SLOT_SRC  = 1;
    localparam int SLOT_DST  = 2;
    localparam int SLOT_LEN  = 3;
    localparam int SLOT_STR  = 4;
    localparam int SLOT_LINK = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_SETUP, ST_READ, ST_WRITE, ST_ROWADV, ST_DONE
    } dma_state_e;
endpackage

// File: rtl/dma_desc_latch.sv
`timescale 1ns/1ps
module dma_desc_latch
    import dma_pkg::*;
#(
    parameter int NWORDS = DESC_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] words [NWORDS]
);
    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[gi] <= '0;
            else if (capture && (idx == IDX_W'(gi)))
                words[gi] <= word_in;
        end
    end
endmodule

// File: rtl/dma_addr_unit.sv
`timescale 1ns/1ps
module dma_addr_unit
    import dma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int NLANES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load     [NLANES],
    input  logic [AW-1:0]       load_val [NLANES],
    input  logic                step     [NLANES],
    input  logic                jump     [NLANES],
    input  logic [STRIDE_W-1:0] stride   [NLANES],
    output logic [AW-1:0]       addr     [NLANES]
);
    localparam logic [AW-1:0] WORD_STEP = AW'(WORD_W / 8);

    for (genvar gl = 0; gl < NLANES; gl++) begin : g_lane
        logic [AW-1:0] jump_amt;
        assign jump_amt = {{(AW-STRIDE_W){stride[gl][STRIDE_W-1]}}, stride[gl]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                addr[gl] <= '0;
            else if (load[gl])
                addr[gl] <= load_val[gl];
            else if (jump[gl])
                addr[gl] <= addr[gl] + jump_amt;
            else if (step[gl])
                addr[gl] <= addr[gl] + WORD_STEP;
        end

        // R3
        step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step[gl] && !load[gl] && !jump[gl]) |=> (addr[gl] == $past(addr[gl]) + WORD_STEP));
    end
endmodule

// File: rtl/dma_row_counter.sv
`timescale 1ns/1ps
module dma_row_counter
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              block_mode,
    input  logic [WORD_W-1:0] len_word,
    input  logic              beat,
    input  logic              next_row,
    output logic              rem_zero,
    output logic              rem_last,
    output logic              last_row,
    output logic [WORD_W-1:0] live_len
);
    localparam int RL_W = ROWS_W + 1;
    localparam logic [WORD_W-1:0] BEAT_BYTES = WORD_W'(WORD_W / 8);

    logic [WORD_W-1:0] row_bytes_q, rem_q, bytes_raw, rem_dec;
    logic [RL_W-1:0]   rows_q, rows_ld;
    logic              mode_q;

    assign bytes_raw = block_mode ? {{(WORD_W-BYTES_W){1'b0}}, len_word[BYTES_W-1:0]} : len_word;
    assign rows_ld   = block_mode ? (RL_W'(len_word[BYTES_W+ROWS_W-1:BYTES_W]) + RL_W'(1)) : RL_W'(1);
    assign rem_dec   = rem_q - BEAT_BYTES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_bytes_q <= '0;
            rem_q       <= '0;
            rows_q      <= '0;
            mode_q      <= 1'b0;
            live_len    <= '0;
        end else if (load) begin
            row_bytes_q <= {bytes_raw[WORD_W-1:2], 2'b00};
            rem_q       <= {bytes_raw[WORD_W-1:2], 2'b00};
            rows_q      <= rows_ld;
            mode_q      <= block_mode;
            live_len    <= len_word;
        end else if (beat) begin
            rem_q    <= rem_dec;
            live_len <= mode_q ? {{(WORD_W-BYTES_W-RL_W){1'b0}}, rows_q, rem_dec[BYTES_W-1:0]}
                               : rem_dec;
        end else if (next_row) begin
            rows_q <= rows_q - RL_W'(1);
            rem_q  <= row_bytes_q;
        end
    end

    assign rem_zero = (rem_q == '0);
    assign rem_last = (rem_q == BEAT_BYTES);
    assign last_row = (rows_q == RL_W'(1));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> !rem_zero);
    // R4
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_row |-> !last_row);
endmodule

// File: rtl/dma_chain_engine.sv
`timescale 1ns/1ps
module dma_chain_engine
    import dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic              clr_end,
    input  logic              clr_int,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              active,
    output logic              paused,
    output logic              end_flag,
    output logic              irq,
    output logic [AW-1:0]     cur_desc,
    output logic [AW-1:0]     live_src,
    output logic [AW-1:0]     live_dst,
    output logic [WORD_W-1:0] live_len
);
    localparam int LANE_SRC = 0;
    localparam int LANE_DST = 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    dma_state_e        state, state_nx;
    logic [IDX_W-1:0]  fidx;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] dw [DESC_WORDS];

    // control strobes produced by the output process
    logic cap, ctr_load, beat, next_row, rd_done, go, stop;
    logic rem_zero, rem_last, last_row;
    logic              a_load [2];
    logic [AW-1:0]     a_val  [2];
    logic              a_step [2];
    logic              a_jump [2];
    logic [STRIDE_W-1:0] a_str [2];
    logic [AW-1:0]     a_addr [2];

    logic [WORD_W-1:0] ctl;
    logic              s_skip, d_skip;
    assign ctl    = dw[SLOT_CTL];
    assign s_skip = ctl[CB_SSKIP];
    assign d_skip = ctl[CB_DSKIP];

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (go) state_nx = ST_FETCH;
            ST_FETCH:  if (mem_ack && fidx == LAST_IDX) state_nx = ST_SETUP;
            ST_SETUP:  state_nx = rem_zero ? ST_DONE : ST_READ;
            ST_READ:   if (rd_done) state_nx = ST_WRITE;
            ST_WRITE:  if (beat) begin
                           if (!rem_last)     state_nx = ST_READ;
                           else if (last_row) state_nx = ST_DONE;
                           else               state_nx = ST_ROWADV;
                       end
            ST_ROWADV: state_nx = ST_READ;
            ST_DONE:   state_nx = stop ? ST_IDLE : ST_FETCH;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fidx     <= '0;
            data_q   <= '0;
            cur_desc <= '0;
            active   <= 1'b0;
            paused   <= 1'b0;
            end_flag <= 1'b0;
            irq      <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_FETCH && state != ST_FETCH) fidx <= '0;
            else if (cap)                                  fidx <= fidx + IDX_W'(1);
            if (state == ST_READ && rd_done) data_q <= s_skip ? '0 : mem_rdata;
            if (state == ST_IDLE && start && chan_en) begin
                cur_desc <= start_addr;
                active   <= (start_addr != '0);
                paused   <= (start_addr == '0);
            end
            if (state == ST_DONE) begin
                cur_desc <= dw[SLOT_LINK][AW-1:0];
                if (stop) begin
                    active <= 1'b0;
                    paused <= 1'b1;
                end
            end
            if (state == ST_DONE)              end_flag <= 1'b1;
            else if (clr_end)                  end_flag <= 1'b0;
            if (state == ST_DONE && ctl[CB_IRQ_EN]) irq <= 1'b1;
            else if (clr_int)                       irq <= 1'b0;
        end
    end

    // ---------------- outputs and strobes ----------------
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = data_q;
        go        = start && chan_en && (start_addr != '0);
        stop      = (dw[SLOT_LINK][AW-1:0] == '0) || !chan_en;
        rd_done   = 1'b0;
        beat      = 1'b0;
        next_row  = 1'b0;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc + {{(AW-IDX_W-2){1'b0}}, fidx, 2'b00};
            end
            ST_READ: begin
                mem_req  = !s_skip;
                mem_addr = a_addr[LANE_SRC];
                rd_done  = s_skip || mem_ack;
            end
            ST_WRITE: begin
                mem_req  = !d_skip;
                mem_we   = !d_skip;
                mem_addr = a_addr[LANE_DST];
                beat     = d_skip || mem_ack;
            end
            ST_ROWADV: next_row = 1'b1;
            default: ;
        endcase
        cap      = (state == ST_FETCH) && mem_ack;
        ctr_load = cap && (fidx == LAST_IDX);

        a_load[LANE_SRC] = ctr_load;
        a_load[LANE_DST] = ctr_load;
        a_val[LANE_SRC]  = dw[SLOT_SRC][AW-1:0];
        a_val[LANE_DST]  = dw[SLOT_DST][AW-1:0];
        a_step[LANE_SRC] = (state == ST_READ) && rd_done && ctl[CB_SINC];
        a_step[LANE_DST] = beat && ctl[CB_DINC];
        a_jump[LANE_SRC] = next_row;
        a_jump[LANE_DST] = next_row;
        a_str[LANE_SRC]  = ctl[CB_BLOCK] ? dw[SLOT_STR][STRIDE_W-1:0] : '0;
        a_str[LANE_DST]  = ctl[CB_BLOCK] ? dw[SLOT_STR][2*STRIDE_W-1:STRIDE_W] : '0;
    end

    dma_desc_latch #(.NWORDS(DESC_WORDS)) u_desc (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .idx     (fidx),
        .word_in (mem_rdata),
        .words   (dw)
    );

    dma_addr_unit #(.AW(AW), .NLANES(2)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (a_load),
        .load_val (a_val),
        .step     (a_step),
        .jump     (a_jump),
        .stride   (a_str),
        .addr     (a_addr)
    );

    // the length word is already captured when the last descriptor word arrives
    dma_row_counter u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ctr_load),
        .block_mode (ctl[CB_BLOCK]),
        .len_word   (dw[SLOT_LEN]),
        .beat       (beat),
        .next_row   (next_row),
        .rem_zero   (rem_zero),
        .rem_last   (rem_last),
        .last_row   (last_row),
        .live_len   (live_len)
    );

    assign live_src = a_addr[LANE_SRC];
    assign live_dst = a_addr[LANE_DST];

    // R10
    held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R7
    run_pause_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && paused));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req);
    // R6
    irq_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> end_flag);
endmodule

// File: tb/sim_dma_chain_engine.sv
`timescale 1ns/1ps
module sim_dma_chain_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b1, start = 1'b0, clr_end = 1'b0, clr_int = 1'b0;
    logic [31:0] start_addr = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        active, paused, end_flag, irq;
    logic [31:0] cur_desc, live_src, live_dst, live_len;

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [0:255];
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] rd_log [0:31];
    logic stall_on = 1'b0, stall_ph = 1'b0;

    always #2.5 clk = ~clk;

    dma_chain_engine #(.AW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start(start), .start_addr(start_addr),
        .clr_end(clr_end), .clr_int(clr_int), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .active(active), .paused(paused), .end_flag(end_flag), .irq(irq),
        .cur_desc(cur_desc), .live_src(live_src), .live_dst(live_dst), .live_len(live_len)
    );

    // memory model: decides the acknowledge at each falling edge
    always @(negedge clk) begin
        logic ack;
        stall_ph <= ~stall_ph;
        ack = mem_req && (!stall_on || stall_ph);
        mem_ack <= ack;
        mem_rdata <= mem[mem_addr[9:2]];
        if (ack && mem_we) begin
            mem[mem_addr[9:2]] = mem_wdata;
            wr_cnt++;
        end else if (ack) begin
            if (rd_cnt < 32) rd_log[rd_cnt] = mem_addr;
            rd_cnt++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] base, ctl, src, dst, len, str, link);
        mem[base[9:2]]     = ctl;
        mem[base[9:2] + 1] = src;
        mem[base[9:2] + 2] = dst;
        mem[base[9:2] + 3] = len;
        mem[base[9:2] + 4] = str;
        mem[base[9:2] + 5] = link;
    endtask

    task automatic run_chain(input logic [31:0] a);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        start = 1'b1; start_addr = a;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4000 && active; i++) @(negedge clk);
        if (active) begin
            n_chk++; n_fail++;
            $display("FAIL R7: chain did not stop, got active=1 expected 0");
        end
        @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk); clr_end = 1'b1; clr_int = 1'b1;
        @(negedge clk); clr_end = 1'b0; clr_int = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 active", {31'b0, active}, 0);
        chk("R1 paused", {31'b0, paused}, 0);
        chk("R1 end", {31'b0, end_flag}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 req", {31'b0, mem_req}, 0);
        chk("R1 desc", cur_desc, 0);
        chk("R1 len", live_len, 0);
        chk("R1 src", live_src | live_dst, 0);
    endtask

    task automatic t_zero_start();
        run_chain(32'h0);
        chk("R9 zero start active", {31'b0, active}, 0);
        chk("R9 zero start paused", {31'b0, paused}, 1);
        chk("R9 zero start no access", rd_cnt + wr_cnt, 0);
    endtask

    task automatic t_linear();
        put_desc(32'h040, 32'h111, 32'h200, 32'h300, 32'd16, 32'h0, 32'h0);
        run_chain(32'h040);
        for (int k = 0; k < 6; k++) chk("R2 fetch order", rd_log[k], 32'h040 + 4 * k);
        for (int k = 0; k < 4; k++) chk("R3 copied word", mem[(32'h300 >> 2) + k], mem[(32'h200 >> 2) + k]);
        chk("R3 reads", rd_cnt, 10);
        chk("R3 writes", wr_cnt, 4);
        chk("R3 src end", live_src, 32'h210);
        chk("R3 dst end", live_dst, 32'h310);
        chk("R3 len end", live_len, 0);
        chk("R6 end set", {31'b0, end_flag}, 1);
        chk("R6 irq set", {31'b0, irq}, 1);
        chk("R7 paused", {31'b0, paused}, 1);
        chk("R7 desc link", cur_desc, 0);
    endtask

    task automatic t_clear();
        @(negedge clk); clr_int = 1'b1;
        @(negedge clk); clr_int = 1'b0;
        chk("R6 clr_int irq", {31'b0, irq}, 0);
        chk("R6 clr_int keeps end", {31'b0, end_flag}, 1);
        @(negedge clk); clr_end = 1'b1;
        @(negedge clk); clr_end = 1'b0;
        chk("R6 clr_end", {31'b0, end_flag}, 0);
    endtask

    task automatic t_block();
        stall_on = 1'b1;
        put_desc(32'h080, 32'h112, 32'h200, 32'h380, (32'd2 << 16) | 32'd8, 32'hFFE8_0004, 32'h0);
        run_chain(32'h080);
        stall_on = 1'b0;
        chk("R4 row0 w0", mem[32'h380 >> 2], mem[32'h200 >> 2]);
        chk("R4 row0 w1", mem[32'h384 >> 2], mem[32'h204 >> 2]);
        chk("R4 row1 w0", mem[32'h370 >> 2], mem[32'h20C >> 2]);
        chk("R4 row1 w1", mem[32'h374 >> 2], mem[32'h210 >> 2]);
        chk("R4 row2 w0", mem[32'h360 >> 2], mem[32'h218 >> 2]);
        chk("R4 row2 w1", mem[32'h364 >> 2], mem[32'h21C >> 2]);
        chk("R4 src end", live_src, 32'h220);
        chk("R4 dst end", live_dst, 32'h368);
        chk("R4 len end", live_len, 32'h0001_0000);
        chk("R10 writes under stall", wr_cnt, 6);
        chk("R6 no irq without enable bit", {31'b0, irq}, 0);
        chk("R6 end", {31'b0, end_flag}, 1);
    endtask

    task automatic t_skip_chain();
        mem[32'h3C0 >> 2] = 32'hFFFF_FFFF; mem[32'h3C4 >> 2] = 32'hFFFF_FFFF;
        mem[32'h3D0 >> 2] = 32'h5555_AAAA; mem[32'h3D4 >> 2] = 32'h5555_AAAA;
        put_desc(32'h0C0, 32'h810, 32'h2F0, 32'h3C0, 32'd8, 32'h0, 32'h0E0);
        put_desc(32'h0E0, 32'h190, 32'h200, 32'h3D0, 32'd8, 32'h0, 32'h0);
        run_chain(32'h0C0);
        chk("R5 zero fill w0", mem[32'h3C0 >> 2], 0);
        chk("R5 zero fill w1", mem[32'h3C4 >> 2], 0);
        chk("R5 no write kept", mem[32'h3D0 >> 2], 32'h5555_AAAA);
        chk("R5 write count", wr_cnt, 2);
        chk("R5 read count", rd_cnt, 14);
        chk("R5 dst still advances", live_dst, 32'h3D8);
        chk("R7 link followed", rd_log[6], 32'h0E0);
        chk("R7 chain end desc", cur_desc, 0);
    endtask

    task automatic t_zero_len();
        clear_flags();
        chk("R6 flags cleared", {30'b0, end_flag, irq}, 0);
        put_desc(32'h100, 32'h001, 32'h200, 32'h3E0, 32'd0, 32'h0, 32'h0);
        run_chain(32'h100);
        chk("R8 only fetch reads", rd_cnt, 6);
        chk("R8 no writes", wr_cnt, 0);
        chk("R8 end", {31'b0, end_flag}, 1);
        chk("R8 irq", {31'b0, irq}, 1);
    endtask

    task automatic t_disable();
        put_desc(32'h120, 32'h110, 32'h200, 32'h3E0, 32'd8, 32'h0, 32'h140);
        put_desc(32'h140, 32'h110, 32'h200, 32'h3E0, 32'd8, 32'h0, 32'h0);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        start = 1'b1; start_addr = 32'h120;
        @(negedge clk);
        start = 1'b0; chan_en = 1'b0;
        for (int i = 0; i < 4000 && active; i++) @(negedge clk);
        chk("R7 disabled stop active", {31'b0, active}, 0);
        chk("R7 disabled stop paused", {31'b0, paused}, 1);
        chk("R7 desc holds link", cur_desc, 32'h140);
        chk("R7 no second fetch", rd_cnt, 8);
    endtask

    task automatic t_start_ignored();
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk); start = 1'b1; start_addr = 32'h040;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 start while disabled", {31'b0, active}, 0);
        chk("R9 no access while disabled", rd_cnt, 0);
        chk("R9 desc unchanged", cur_desc, 32'h140);
        chan_en = 1'b1;
        put_desc(32'h160, 32'h110, 32'h200, 32'h3A0, 32'h22, 32'h0, 32'h0);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        start = 1'b1; start_addr = 32'h160;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; start_addr = 32'h040;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 4000 && active; i++) @(negedge clk);
        chk("R9 busy start ignored reads", rd_cnt, 14);
        chk("R3 length low bits ignored", wr_cnt, 8);
        chk("R9 first fetch", rd_log[0], 32'h160);
        chk("R3 last word", mem[32'h3BC >> 2], mem[32'h21C >> 2]);
        chk("R9 final desc", cur_desc, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + i;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_start();
        t_linear();
        t_clear();
        t_block();
        t_skip_chain();
        t_zero_len();
        t_disable();
        t_start_ignored();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule